// File: doc/BRIEF.md
# Strict-Priority Plus Deficit Round-Robin Egress Scheduler

This block decides, every clock, which of four transmit queues of one egress port may hand its head-of-line packet to the link. Queue 0 is a strict-priority queue. It is granted whenever it holds a packet, regardless of what the other queues are doing. Queues 1, 2 and 3 are normal queues. They share the remaining service through deficit weighted round-robin, each with its own byte quantum.

A normal queue keeps a signed credit counter. It may send while that credit is positive, even when the packet is longer than the credit left. The overspend then stays in the counter as a negative value and is paid back out of the next quantum. Over time, the bytes each normal queue sends approach the ratio of the quanta.

The block sees only the head of each queue: a valid flag and, for normal queues, a length in bytes. It answers with a one-hot selection qualified by a valid and ready handshake. It holds no packet storage.

The controller has two states:
- `ST_ROUND`: normal arbitration.
- `ST_REFILL`: a single cycle in which quanta are credited.

It has three transitions:
- **exhaust** (`ST_ROUND` to `ST_REFILL`): taken when the strict queue is empty, at least one normal queue holds a packet, and none of the normal queues holding a packet has positive credit.
- **restart** (`ST_REFILL` to `ST_ROUND`): always taken after one cycle.
- **continue** (`ST_ROUND` to `ST_ROUND`): taken in every other case.

Top module: `prio_dwrr_sched`

## Requirements
- R1: While reset is asserted the outputs are idle, and after reset every credit is zero. The first grant to a normal queue therefore always follows a refill.
- R2: If `hol_valid[0]` is 1, `deq_sel` is `4'b0001` in that same cycle, in either state.
- R3: `deq_sel` has at most one bit set, and `deq_valid` is 1 exactly when a bit of `deq_sel` is set. Bit k of `deq_sel` selects queue k.
- R4: In `ST_ROUND` with the strict queue empty, a normal queue is eligible when it holds a packet and its credit is greater than zero. The grant goes to the first eligible queue found by searching from the round pointer in the cyclic order 1, 2, 3. The pointer is queue 1 after reset.
- R5: When a normal queue completes a handshake (`deq_valid && deq_ready` with its bit selected), its credit drops by its `hol_len` and the pointer moves to that queue. It therefore keeps the grant while its credit stays positive.
- R6: A cycle without a handshake leaves every credit and the pointer unchanged, except for refill (R7) and clearing (R8).
- R7: The **exhaust** transition leads to exactly one `ST_REFILL` cycle. In that cycle, no normal queue is granted, each non-empty normal queue's credit rises by its quantum, and the pointer returns to queue 1.
- R8: In any cycle in which a normal queue is empty, its credit is cleared to zero.
- R9: Overspend carries over. With a quantum of 500 and 1500-byte packets on a lone queue 1, the second grant comes seven cycles after the first. Credit after the first send is -1000, and reaching +500 again takes three refills.
- R10: With all three normal queues permanently backlogged, the bytes sent by each queue converge to the ratio of the quanta, within 5 %.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hol_valid | input | N_NORM+1 | Bit k is 1 when queue k holds a packet |
| hol_len | input | N_NORM*LEN_W | Head-of-line length in bytes of normal queue k, at bits [(k-1)*LEN_W +: LEN_W] |
| quantum | input | N_NORM*QNT_W | Byte quantum of normal queue k, at bits [(k-1)*QNT_W +: QNT_W] |
| deq_ready | input | 1 | The link takes the selected head packet this cycle |
| deq_valid | output | 1 | A queue is selected |
| deq_sel | output | N_NORM+1 | One-hot selection of the granted queue |

## Verification
The bound checker checks these rules on every cycle:
- the strict queue's precedence;
- the one-hot form of the grant;
- that a grant only goes to a non-empty queue with positive credit;
- that a refill lasts one cycle and grants no normal queue;
- that credit rises by exactly the quantum during a refill;
- that credit holds through a stall;
- that credit clears on an empty queue.

Other behaviour needs multi-cycle histories, which only the bench's scenarios can show:
- the order in which queues are visited;
- a queue keeping the grant until its credit runs out;
- the seven-cycle recovery from a 1000-byte overspend;
- the convergence of byte shares to the quanta.

// File: rtl/prio_dwrr_pkg.sv
package prio_dwrr_pkg;

    // Controller phase: normal arbitration or a single quantum-credit cycle.
    typedef enum logic [0:0] {
        ST_ROUND  = 1'b0,
        ST_REFILL = 1'b1
    } sched_state_e;

endpackage

// File: rtl/prio_dwrr_deficit.sv
// Signed credit counter for one normal queue.
module prio_dwrr_deficit #(
    parameter int LEN_W = 14,
    parameter int QNT_W = 16,
    parameter int DC_W  = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    nonempty,
    input  logic                    charge,
    input  logic                    refill,
    input  logic [LEN_W-1:0]        pkt_len,
    input  logic [QNT_W-1:0]        quantum,
    output logic signed [DC_W-1:0]  credit,
    output logic                    eligible
);

    logic signed [DC_W-1:0] credit_d;
    logic signed [DC_W-1:0] len_ext;
    logic signed [DC_W-1:0] qnt_ext;

    assign len_ext = $signed({{(DC_W-LEN_W){1'b0}}, pkt_len});
    assign qnt_ext = $signed({{(DC_W-QNT_W){1'b0}}, quantum});

    always_comb begin
        credit_d = credit;
        if (!nonempty) begin
            credit_d = '0;
        end else if (refill) begin
            credit_d = credit + qnt_ext;
        end else if (charge) begin
            credit_d = credit - len_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            credit <= '0;
        end else begin
            credit <= credit_d;
        end
    end

    assign eligible = nonempty && !credit[DC_W-1] && (credit != '0);

endmodule

// File: rtl/prio_dwrr_pick.sv
// First eligible normal queue, searching cyclically from the round pointer.
module prio_dwrr_pick #(
    parameter int N  = 3,
    parameter int PW = 2
) (
    input  logic [N-1:0]  elig,
    input  logic [PW-1:0] ptr,
    output logic          found,
    output logic [PW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(ptr) + k;
            if (j >= N) begin
                j = j - N;
            end
            if (!found && elig[j]) begin
                found = 1'b1;
                idx   = PW'(j);
            end
        end
    end

endmodule

// File: rtl/prio_dwrr_sched.sv
// Egress scheduler: queue 0 strict priority, queues 1..N_NORM deficit round-robin.
module prio_dwrr_sched
    import prio_dwrr_pkg::*;
#(
    parameter int N_NORM = 3,
    parameter int LEN_W  = 14,
    parameter int QNT_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_NORM:0]           hol_valid,
    input  logic [N_NORM*LEN_W-1:0]   hol_len,
    input  logic [N_NORM*QNT_W-1:0]   quantum,
    input  logic                      deq_ready,
    output logic                      deq_valid,
    output logic [N_NORM:0]           deq_sel
);

    localparam int NQ   = N_NORM + 1;
    localparam int PW   = $clog2(N_NORM);
    localparam int DC_W = ((LEN_W > QNT_W) ? LEN_W : QNT_W) + 2;

    sched_state_e                        state_q;
    sched_state_e                        state_d;
    logic [PW-1:0]                       ptr_q;
    logic [PW-1:0]                       ptr_d;
    logic [N_NORM-1:0][DC_W-1:0]         dc_q;
    logic [N_NORM-1:0]                   elig;
    logic                                found;
    logic [PW-1:0]                       idx;
    logic                                strict_req;
    logic                                norm_req;
    logic                                refill_now;

    assign strict_req = hol_valid[0];
    assign norm_req   = |hol_valid[NQ-1:1];
    assign refill_now = (state_q == ST_REFILL);

    // Credit counters, one per normal queue.
    for (genvar g = 0; g < N_NORM; g++) begin : g_credit
        prio_dwrr_deficit #(
            .LEN_W (LEN_W),
            .QNT_W (QNT_W),
            .DC_W  (DC_W)
        ) u_deficit (
            .clk      (clk),
            .rst_n    (rst_n),
            .nonempty (hol_valid[g+1]),
            .charge   (deq_sel[g+1] & deq_ready),
            .refill   (refill_now),
            .pkt_len  (hol_len[g*LEN_W +: LEN_W]),
            .quantum  (quantum[g*QNT_W +: QNT_W]),
            .credit   (dc_q[g]),
            .eligible (elig[g])
        );
    end

    prio_dwrr_pick #(
        .N  (N_NORM),
        .PW (PW)
    ) u_pick (
        .elig  (elig),
        .ptr   (ptr_q),
        .found (found),
        .idx   (idx)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ROUND;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // Next state and round pointer.
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_ROUND: begin
                if (!strict_req && !found && norm_req) begin
                    state_d = ST_REFILL;               // exhaust
                end else begin
                    state_d = ST_ROUND;                // continue
                end
                if (!strict_req && found && deq_ready) begin
                    ptr_d = idx;
                end
            end
            ST_REFILL: begin
                state_d = ST_ROUND;                    // restart
                ptr_d   = '0;
            end
            default: begin
                state_d = ST_ROUND;
                ptr_d   = '0;
            end
        endcase
    end

    // Grant outputs.
    always_comb begin
        deq_sel = '0;
        unique case (state_q)
            ST_ROUND: begin
                if (strict_req) begin
                    deq_sel[0] = 1'b1;
                end else if (found) begin
                    deq_sel[int'(idx) + 1] = 1'b1;
                end
            end
            ST_REFILL: begin
                if (strict_req) begin
                    deq_sel[0] = 1'b1;
                end
            end
            default: begin
                deq_sel = '0;
            end
        endcase
        deq_valid = |deq_sel;
    end

endmodule

// File: rtl/prio_dwrr_sched_chk.sv
module prio_dwrr_sched_chk
    import prio_dwrr_pkg::*;
#(
    parameter int N_NORM = 3,
    parameter int LEN_W  = 14,
    parameter int QNT_W  = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [N_NORM:0]                        hol_valid,
    input  logic [N_NORM*QNT_W-1:0]                quantum,
    input  logic                                   deq_ready,
    input  logic                                   deq_valid,
    input  logic [N_NORM:0]                        deq_sel,
    input  sched_state_e                           state_q,
    input  logic [N_NORM-1:0][((LEN_W > QNT_W) ? LEN_W : QNT_W)+1:0] dc_q
);

    localparam int NQ   = N_NORM + 1;
    localparam int DC_W = ((LEN_W > QNT_W) ? LEN_W : QNT_W) + 2;

    p_strict_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hol_valid[0] |-> (deq_sel == NQ'(1)));

    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(deq_sel) && (deq_valid == (deq_sel != '0)));

    p_grant_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_sel & ~hol_valid) == '0);

    p_refill_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REFILL) |-> (deq_sel[NQ-1:1] == '0));

    p_refill_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REFILL) |=> (state_q == ST_ROUND));

    for (genvar g = 0; g < N_NORM; g++) begin : g_q
        p_credit_positive_r4: assert property (@(posedge clk) disable iff (!rst_n)
            deq_sel[g+1] |-> (!dc_q[g][DC_W-1] && (dc_q[g] != '0)));

        p_stall_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ((state_q == ST_ROUND) && hol_valid[g+1] && !(deq_sel[g+1] && deq_ready))
            |=> (dc_q[g] == $past(dc_q[g])));

        p_refill_adds_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ((state_q == ST_REFILL) && hol_valid[g+1])
            |=> (dc_q[g] == DC_W'($past(dc_q[g]) + DC_W'($past(quantum[g*QNT_W +: QNT_W])))));

        p_empty_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !hol_valid[g+1] |=> (dc_q[g] == '0));
    end

endmodule

bind prio_dwrr_sched prio_dwrr_sched_chk #(
    .N_NORM (N_NORM),
    .LEN_W  (LEN_W),
    .QNT_W  (QNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hol_valid (hol_valid),
    .quantum   (quantum),
    .deq_ready (deq_ready),
    .deq_valid (deq_valid),
    .deq_sel   (deq_sel),
    .state_q   (state_q),
    .dc_q      (dc_q)
);

// File: tb/tb_prio_dwrr_sched.sv
module tb_prio_dwrr_sched;

    localparam int N_NORM = 3;
    localparam int LEN_W  = 14;
    localparam int QNT_W  = 16;
    localparam int NQ     = N_NORM + 1;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [NQ-1:0]           hol_valid;
    logic [N_NORM*LEN_W-1:0] hol_len;
    logic [N_NORM*QNT_W-1:0] quantum;
    logic                    deq_ready;
    logic                    deq_valid;
    logic [NQ-1:0]           deq_sel;

    always #5 clk = ~clk;

    prio_dwrr_sched #(
        .N_NORM (N_NORM),
        .LEN_W  (LEN_W),
        .QNT_W  (QNT_W)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hol_valid (hol_valid),
        .hol_len   (hol_len),
        .quantum   (quantum),
        .deq_ready (deq_ready),
        .deq_valid (deq_valid),
        .deq_sel   (deq_sel)
    );

    int          n_vec = 0;
    int          n_bad = 0;
    int          cnt   [NQ];     // packets waiting; -1 means endless backlog
    int          plen  [NQ];
    int          qnt   [NQ];
    int          m_dc  [NQ];
    bit          m_refill;
    int          m_ptr;
    longint      bytes [NQ];
    int          cyc;
    int          order [64];
    int          gcyc  [64];
    int          norder;
    string       tag;
    bit          rdy_rand;
    logic [15:0] lfsr = 16'hACE1;
    bit          done = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_inputs();
        for (int i = 0; i < NQ; i++) begin
            hol_valid[i] = (cnt[i] != 0);
            if (i > 0) begin
                hol_len[(i-1)*LEN_W +: LEN_W] = LEN_W'(plen[i]);
                quantum[(i-1)*QNT_W +: QNT_W] = QNT_W'(qnt[i]);
            end
        end
        deq_ready = rdy_rand ? lfsr[0] : 1'b1;
    endtask

    task automatic clear_traffic();
        for (int i = 0; i < NQ; i++) begin
            cnt[i] = 0; plen[i] = 64; qnt[i] = 0; m_dc[i] = 0; bytes[i] = 0;
        end
        m_refill = 1'b0;
        m_ptr    = 1;
        cyc      = 0;
        norder   = 0;
        rdy_rand = 1'b0;
    endtask

    task automatic do_reset();
        clear_traffic();
        rst_n = 1'b0;
        drive_inputs();
        repeat (3) @(negedge clk);
        #1;
        check(deq_valid == 1'b0 && deq_sel == '0, "R1", longint'(deq_sel), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle: drive, compare with the behavioural model, advance the model.
    task automatic step();
        int  exp;
        int  gq;
        bit  hs;
        bit  any_norm;
        bit  nxt_refill;
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        drive_inputs();
        #1;
        exp = 0;
        gq  = -1;
        if (cnt[0] != 0) begin
            exp = 1; gq = 0;
        end else if (!m_refill) begin
            for (int k = 0; k < N_NORM; k++) begin
                int j;
                j = ((m_ptr - 1 + k) % N_NORM) + 1;
                if (gq < 0 && cnt[j] != 0 && m_dc[j] > 0) begin
                    exp = 1 << j; gq = j;
                end
            end
        end
        check(deq_sel == NQ'(exp) && deq_valid == (exp != 0), tag, longint'(deq_sel), exp);
        check($onehot0(deq_sel) && (deq_valid == (deq_sel != '0)), "R3", longint'(deq_sel), exp);
        hs = (gq >= 0) && deq_ready;
        any_norm = 1'b0;
        for (int j = 1; j < NQ; j++) any_norm |= (cnt[j] != 0);
        nxt_refill = !m_refill && (cnt[0] == 0) && (gq < 0) && any_norm;
        for (int j = 1; j < NQ; j++) begin
            if (cnt[j] == 0)           m_dc[j] = 0;
            else if (m_refill)         m_dc[j] += qnt[j];
            else if (hs && gq == j)    m_dc[j] -= plen[j];
        end
        if (m_refill)            m_ptr = 1;
        else if (hs && gq > 0)   m_ptr = gq;
        m_refill = nxt_refill;
        if (hs) begin
            bytes[gq] += plen[gq];
            if (norder < 64) begin
                order[norder] = gq; gcyc[norder] = cyc; norder++;
            end
            if (cnt[gq] > 0) cnt[gq]--;
        end
        cyc++;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        clear_traffic();
        hol_valid = '0; hol_len = '0; quantum = '0; deq_ready = 1'b0;

        // R1 / R7: zero credit after reset, so a refill precedes the first grant.
        tag = "R1";
        do_reset();
        qnt[1] = 1000; qnt[2] = 1000; qnt[3] = 1000;
        cnt[1] = 1; plen[1] = 100;
        repeat (5) step();
        check(norder == 1 && order[0] == 1, "R1", order[0], 1);
        check(gcyc[0] == 2, "R7", gcyc[0], 2);

        // R4: cyclic visiting order 1, 2, 3.
        tag = "R4";
        do_reset();
        qnt[1] = 1000; qnt[2] = 1000; qnt[3] = 1000;
        cnt[1] = 1; cnt[2] = 1; cnt[3] = 1;
        plen[1] = 100; plen[2] = 100; plen[3] = 100;
        repeat (8) step();
        check(norder == 3, "R4", norder, 3);
        check(order[0] == 1 && order[1] == 2 && order[2] == 3, "R4",
              order[0]*100 + order[1]*10 + order[2], 123);

        // R5: a queue keeps the grant while its credit stays positive.
        tag = "R5";
        do_reset();
        qnt[1] = 350; qnt[2] = 350; qnt[3] = 350;
        cnt[1] = 6; cnt[2] = 2; plen[1] = 100; plen[2] = 100;
        repeat (16) step();
        check(norder == 8, "R5", norder, 8);
        check(order[0] == 1 && order[3] == 1 && order[4] == 2 && order[5] == 2 &&
              order[6] == 1 && order[7] == 1, "R5",
              order[3]*1000 + order[4]*100 + order[5]*10 + order[6], 1221);

        // R2: strict queue pre-empts, including while a refill is pending.
        tag = "R2";
        do_reset();
        qnt[1] = 1000; qnt[2] = 1000; qnt[3] = 1000;
        cnt[0] = 5; cnt[1] = 3; cnt[2] = 3; cnt[3] = 3;
        plen[1] = 300; plen[2] = 300; plen[3] = 300;
        repeat (6) step();
        check(order[0] == 0 && order[4] == 0, "R2", order[4], 0);
        repeat (6) step();
        cnt[0] = 2;
        repeat (20) step();

        // R6: random back-pressure on a mixed backlog.
        tag = "R6";
        do_reset();
        rdy_rand = 1'b1;
        qnt[1] = 500; qnt[2] = 800; qnt[3] = 1200;
        cnt[0] = 4; cnt[1] = -1; cnt[2] = -1; cnt[3] = -1;
        plen[1] = 64; plen[2] = 700; plen[3] = 1500;
        repeat (400) step();
        rdy_rand = 1'b0;

        // R9 / R7: overspend of 1000 bytes repaid over later refills.
        tag = "R9 R7";
        do_reset();
        qnt[1] = 500; cnt[1] = 2; plen[1] = 1500;
        repeat (14) step();
        check(norder == 2, "R9", norder, 2);
        check(gcyc[1] - gcyc[0] == 7, "R9", gcyc[1] - gcyc[0], 7);

        // R8: a queue that empties loses its remaining credit.
        tag = "R8";
        do_reset();
        qnt[1] = 1000; cnt[1] = 1; plen[1] = 100;
        repeat (4) step();
        cnt[1] = 1;
        step();
        check(norder == 1, "R8", norder, 1);
        repeat (3) step();
        check(norder == 2 && gcyc[1] == 6, "R8", gcyc[1], 6);

        // R10: long-run byte shares follow the quanta 1:2:3.
        tag = "R10";
        do_reset();
        qnt[1] = 300; qnt[2] = 600; qnt[3] = 900;
        cnt[1] = -1; cnt[2] = -1; cnt[3] = -1;
        plen[1] = 200; plen[2] = 500; plen[3] = 700;
        repeat (3000) step();
        check((bytes[2] - 2*bytes[1]) * 20 <= 2*bytes[1] &&
              (2*bytes[1] - bytes[2]) * 20 <= 2*bytes[1], "R10", bytes[2], 2*bytes[1]);
        check((bytes[3] - 3*bytes[1]) * 20 <= 3*bytes[1] &&
              (3*bytes[1] - bytes[3]) * 20 <= 3*bytes[1], "R10", bytes[3], 3*bytes[1]);

        finish_run();
    end

endmodule